// File: doc/BRIEF.md
# Converter Result Readout Port

This block is the digital output side of a 16-bit sampling converter. A one-cycle strobe latches a completed result word, which a host can then read either as a 16-bit parallel word or as a serial bit stream. The same sixteen output pins serve both roles. In serial mode, pin 8 carries the data bit, pin 9 the serial clock, pin 10 a frame marker and pin 11 a read-error flag. Pins 15 to 12 are released, and so are pins 7 to 0.

The serial clock comes from one of two places. In master mode the port divides the system clock by 2*SCLK_HALF and sends exactly sixteen clock periods per read. In slave mode the host supplies the clock on `sclk_i`, and the port samples it with the system clock. Several mode inputs are sampled live: the result format (offset binary or two's complement), the clock edge on which slave data changes, and the polarity of the frame marker. Electrical tri-state is modelled as one output-enable bit per pin.

Top module: `adc_readout_port`

## Requirements
- R1: A serial read sends the latched word most significant bit first. The word is loaded into a shift register at the start of the read, and all 16 bits appear on pin 8.
- R2: With `twos_i`=1, bit 15 of the latched word is inverted on output. With `twos_i`=0 the word is sent unchanged. In parallel mode (`serial_i`=0), `bus_o` carries the formatted word.
- R3: In slave mode with `inv_clk_i`=0, pin 8 changes in the system cycle after a rising `sclk_i` is sampled, and a falling `sclk_i` leaves it unchanged. With `inv_clk_i`=1 the roles of the two edges are swapped. A host that samples on the other edge recovers the whole word.
- R4: In master mode, pin 9 idles low and starts low when a read begins. Each level lasts SCLK_HALF system cycles, and a read gives exactly 16 rising edges. Pin 8 changes only where pin 9 falls.
- R5: Pin 10 is at its active level from the start of a master read until the 16th falling edge of pin 9, and inactive at all other times, including in slave mode. The active level is 1 when `inv_sync_i`=0 and 0 when `inv_sync_i`=1.
- R6: Output enables are set only while `cs_n_i`=0 and `rd_n_i`=0. In parallel mode all 16 enables are set.
- R7: While `cs_n_i`=1, edges on `sclk_i` do not advance a slave read. When the host selects the port again, the read continues from the same bit.
- R8: If `latch_i` arrives while a slave read is unfinished, the read is dropped: pin 8 goes to 0 and further clock edges have no effect. In that case pin 11 is 1 for exactly the one cycle after the strobe. A strobe at any other time leaves pin 11 at 0.
- R9: In serial mode, pins 15..12 and 7..0 are driven 0 and never enabled. The enable for pin 9 is set only in master mode, so a selected slave read enables pins 8, 10 and 11 only (0x0D00), and a selected master read enables 0x0F00.
- R10: A read starts only when the port goes from unselected to selected while no read is running. Staying selected after a read does not start another one. A strobe during a master read does not disturb the word being sent and does not raise pin 11.
- R11: After reset the held word is 0, pins 8, 9 and 11 are 0, and pin 10 sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_i | input | 1 | One-cycle strobe: conversion complete, capture `result_i` |
| result_i | input | 16 | Conversion result, offset binary |
| serial_i | input | 1 | 1 selects serial pin roles, 0 selects the parallel bus |
| twos_i | input | 1 | 1 selects two's complement output |
| ext_clk_i | input | 1 | 1 means the host supplies the serial clock (slave mode) |
| inv_clk_i | input | 1 | Slave mode: 0 means data changes on the rising edge, 1 on the falling edge |
| inv_sync_i | input | 1 | 1 makes the frame marker active low |
| cs_n_i | input | 1 | Active-low chip select, also gates `sclk_i` |
| rd_n_i | input | 1 | Active-low read enable |
| sclk_i | input | 1 | Host serial clock, sampled by `clk` |
| bus_o | output | 16 | Pin values |
| bus_oe_o | output | 16 | Per-pin output enable |

## Verification
Master reads are run with both frame-marker polarities and with two words. One of them is in two's complement, so a missing MSB inversion shows up apart from a bit-order fault. Slave reads cover all four combinations of clock edge and marker polarity. One of them is paused with chip select high while the clock keeps toggling, which tells a correct chip-select gate apart from a lost or duplicated bit. An incomplete slave read is cut off by a strobe, and the read that follows carries the new word; a strobe during a master read and one after a finished slave read show that pin 11 rises only in the faulted case.

// File: rtl/adc_rdout_pkg.sv
`timescale 1ns/1ps
package adc_rdout_pkg;
    localparam int unsigned RES_W = 16;
    localparam int unsigned CNT_W = $clog2(RES_W);

    localparam int unsigned PIN_SDOUT = 8;
    localparam int unsigned PIN_SCLK  = 9;
    localparam int unsigned PIN_SYNC  = 10;
    localparam int unsigned PIN_ERR   = 11;

    typedef logic [RES_W-1:0] word_t;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_MASTER = 2'd1,
        ENG_SLAVE  = 2'd2
    } eng_e;

    typedef struct packed {
        eng_e             mode;
        word_t            shreg;
        logic             sdout;
        logic [CNT_W-1:0] cnt;
    } eng_state_t;

    typedef struct packed {
        word_t held;
        logic  sel_p;
        logic  sclk_p;
        logic  err;
    } port_state_t;
endpackage

// File: rtl/readout_format.sv
`timescale 1ns/1ps
module readout_format
    import adc_rdout_pkg::*;
(
    input  word_t raw_i,
    input  logic  twos_i,
    output word_t fmt_o
);
    localparam word_t SIGN_MASK = word_t'(1) << (RES_W - 1);

    // Two's complement view of an offset-binary code differs only in the top bit.
    assign fmt_o = twos_i ? (raw_i ^ SIGN_MASK) : raw_i;
endmodule

// File: rtl/readout_sclk_gen.sv
`timescale 1ns/1ps
module readout_sclk_gen #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o
);
    localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             sclk;
    } gen_t;

    gen_t g_d, g_q;
    logic wrap;

    always_comb begin
        wrap = (g_q.div == DIV_LAST);
        g_d  = g_q;
        if (!run_i) begin
            g_d.div  = '0;
            g_d.sclk = 1'b0;
        end else if (wrap) begin
            g_d.div  = '0;
            g_d.sclk = !g_q.sclk;
        end else begin
            g_d.div = g_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign sclk_o = g_q.sclk;
    // High in the cycle whose closing edge takes the clock low.
    assign fall_o = run_i & wrap & g_q.sclk;
endmodule

// File: rtl/readout_shifter.sv
`timescale 1ns/1ps
module readout_shifter
    import adc_rdout_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t word_i,
    input  logic  start_m_i,
    input  logic  start_s_i,
    input  logic  fall_m_i,
    input  logic  upd_s_i,
    input  logic  abort_i,
    output logic  sdout_o,
    output logic  busy_m_o,
    output logic  busy_s_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_W - 1);

    eng_state_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (abort_i) begin
            e_d.mode  = ENG_IDLE;
            e_d.sdout = 1'b0;
            e_d.cnt   = '0;
        end else begin
            case (e_q.mode)
                ENG_IDLE: begin
                    if (start_m_i) begin
                        e_d.mode  = ENG_MASTER;
                        e_d.sdout = word_i[RES_W-1];
                        e_d.shreg = word_i << 1;
                        e_d.cnt   = '0;
                    end else if (start_s_i) begin
                        e_d.mode  = ENG_SLAVE;
                        e_d.shreg = word_i;
                        e_d.cnt   = '0;
                    end
                end
                ENG_MASTER: begin
                    if (fall_m_i) begin
                        if (e_q.cnt == LAST) begin
                            e_d.mode = ENG_IDLE;
                        end else begin
                            e_d.sdout = e_q.shreg[RES_W-1];
                            e_d.shreg = e_q.shreg << 1;
                        end
                        e_d.cnt = e_q.cnt + 1'b1;
                    end
                end
                ENG_SLAVE: begin
                    if (upd_s_i) begin
                        e_d.sdout = e_q.shreg[RES_W-1];
                        e_d.shreg = e_q.shreg << 1;
                        e_d.cnt   = e_q.cnt + 1'b1;
                        if (e_q.cnt == LAST) e_d.mode = ENG_IDLE;
                    end
                end
                default: e_d.mode = ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign sdout_o  = e_q.sdout;
    assign busy_m_o = (e_q.mode == ENG_MASTER);
    assign busy_s_o = (e_q.mode == ENG_SLAVE);
endmodule

// File: rtl/readout_pin_mux.sv
`timescale 1ns/1ps
module readout_pin_mux
    import adc_rdout_pkg::*;
(
    input  logic  serial_i,
    input  logic  ext_i,
    input  logic  sel_i,
    input  word_t par_i,
    input  logic  sdout_i,
    input  logic  int_sclk_i,
    input  logic  sync_act_i,
    input  logic  inv_sync_i,
    input  logic  err_i,
    output word_t bus_o,
    output word_t oe_o
);
    for (genvar p = 0; p < RES_W; p++) begin : g_pin
        if (p == PIN_SDOUT) begin : g_sd
            assign bus_o[p] = serial_i ? sdout_i : par_i[p];
            assign oe_o[p]  = sel_i;
        end else if (p == PIN_SCLK) begin : g_ck
            assign bus_o[p] = serial_i ? (int_sclk_i & ~ext_i) : par_i[p];
            assign oe_o[p]  = sel_i & ~(serial_i & ext_i);
        end else if (p == PIN_SYNC) begin : g_sy
            assign bus_o[p] = serial_i ? (sync_act_i ^ inv_sync_i) : par_i[p];
            assign oe_o[p]  = sel_i;
        end else if (p == PIN_ERR) begin : g_er
            assign bus_o[p] = serial_i ? err_i : par_i[p];
            assign oe_o[p]  = sel_i;
        end else begin : g_dat
            assign bus_o[p] = serial_i ? 1'b0 : par_i[p];
            assign oe_o[p]  = sel_i & ~serial_i;
        end
    end
endmodule

// File: rtl/adc_readout_port.sv
`timescale 1ns/1ps
module adc_readout_port
    import adc_rdout_pkg::*;
#(
    parameter int unsigned SCLK_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             serial_i,
    input  logic             twos_i,
    input  logic             ext_clk_i,
    input  logic             inv_clk_i,
    input  logic             inv_sync_i,
    input  logic             cs_n_i,
    input  logic             rd_n_i,
    input  logic             sclk_i,
    output logic [RES_W-1:0] bus_o,
    output logic [RES_W-1:0] bus_oe_o
);
    port_state_t p_d, p_q;
    word_t fmt_word;
    logic  sel, sel_rise, sclk_rise, sclk_fall;
    logic  start_m, start_s, upd_s, abort;
    logic  eng_sdout, eng_busy_m, eng_busy_s;
    logic  int_sclk, int_fall;

    always_comb begin
        sel       = ~cs_n_i & ~rd_n_i;
        sel_rise  = sel & ~p_q.sel_p;
        sclk_rise = sclk_i & ~p_q.sclk_p;
        sclk_fall = ~sclk_i & p_q.sclk_p;
        start_m   = serial_i & ~ext_clk_i & sel_rise;
        start_s   = serial_i & ext_clk_i & sel_rise;
        // Chip select gates the host clock; the update edge follows inv_clk_i.
        upd_s     = ~cs_n_i & eng_busy_s & (inv_clk_i ? sclk_fall : sclk_rise);
        abort     = latch_i & eng_busy_s;

        p_d        = p_q;
        p_d.sel_p  = sel;
        p_d.sclk_p = sclk_i;
        p_d.err    = abort;
        if (latch_i) p_d.held = result_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    readout_format u_fmt (
        .raw_i  (p_q.held),
        .twos_i (twos_i),
        .fmt_o  (fmt_word)
    );

    readout_sclk_gen #(.HALF(SCLK_HALF)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_busy_m),
        .sclk_o (int_sclk),
        .fall_o (int_fall)
    );

    readout_shifter u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_i    (fmt_word),
        .start_m_i (start_m),
        .start_s_i (start_s),
        .fall_m_i  (int_fall),
        .upd_s_i   (upd_s),
        .abort_i   (abort),
        .sdout_o   (eng_sdout),
        .busy_m_o  (eng_busy_m),
        .busy_s_o  (eng_busy_s)
    );

    readout_pin_mux u_mux (
        .serial_i   (serial_i),
        .ext_i      (ext_clk_i),
        .sel_i      (sel),
        .par_i      (fmt_word),
        .sdout_i    (eng_sdout),
        .int_sclk_i (int_sclk),
        .sync_act_i (eng_busy_m),
        .inv_sync_i (inv_sync_i),
        .err_i      (p_q.err),
        .bus_o      (bus_o),
        .oe_o       (bus_oe_o)
    );
endmodule

// File: rtl/readout_port_checks.sv
`timescale 1ns/1ps
module readout_port_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        latch_i,
    input logic        serial_i,
    input logic [15:0] bus_oe_o,
    input logic        busy_m,
    input logic        busy_s,
    input logic        sdout,
    input logic        int_sclk,
    input logic        fmt_msb,
    input logic        err
);
    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_err_needs_slave_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(busy_s));

    assert_abort_ends_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && busy_s) |=> !busy_s);

    assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_m) |-> (sdout == $past(fmt_msb)));

    assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_m |-> !int_sclk);

    assert_one_engine_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_m, busy_s}));

    assert_upper_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        serial_i |-> (bus_oe_o[15:12] == 4'b0000));
endmodule

bind adc_readout_port readout_port_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_i  (latch_i),
    .serial_i (serial_i),
    .bus_oe_o (bus_oe_o),
    .busy_m   (eng_busy_m),
    .busy_s   (eng_busy_s),
    .sdout    (eng_sdout),
    .int_sclk (int_sclk),
    .fmt_msb  (fmt_word[15]),
    .err      (p_q.err)
);

// File: tb/adc_readout_port_bench.sv
`timescale 1ns/1ps
module adc_readout_port_bench;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic latch_i = 1'b0;
    logic [15:0] result_i = '0;
    logic serial_i = 1'b0, twos_i = 1'b0, ext_clk_i = 1'b0;
    logic inv_clk_i = 1'b0, inv_sync_i = 1'b0;
    logic cs_n_i = 1'b1, rd_n_i = 1'b1, sclk_i = 1'b0;
    logic [15:0] bus_o, bus_oe_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_readout_port #(.SCLK_HALF(HALF)) u_adc_readout_port (
        .clk(clk), .rst_n(rst_n), .latch_i(latch_i), .result_i(result_i),
        .serial_i(serial_i), .twos_i(twos_i), .ext_clk_i(ext_clk_i),
        .inv_clk_i(inv_clk_i), .inv_sync_i(inv_sync_i), .cs_n_i(cs_n_i),
        .rd_n_i(rd_n_i), .sclk_i(sclk_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
    );

    function automatic logic [15:0] fmtw(input logic [15:0] w, input logic t);
        return t ? {~w[15], w[14:0]} : w;
    endfunction

    // ---------------- behavioural reference ----------------
    int   m_mode = 0;          // 0 none, 1 master read, 2 slave read
    bit   m_q[$];
    int   m_tick = 0;
    logic m_sdout = 0, m_err = 0, m_selp = 0, m_sclkp = 0;
    logic [15:0] m_held = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_q.delete(); m_tick = 0;
            m_sdout = 0; m_err = 0; m_selp = 0; m_sclkp = 0; m_held = '0;
        end else begin
            logic sel, rise, edge_ok, new_err;
            logic [15:0] w;
            sel = !cs_n_i && !rd_n_i;
            rise = sel && !m_selp;
            edge_ok = (m_mode == 2) && !cs_n_i &&
                      (inv_clk_i ? (!sclk_i && m_sclkp) : (sclk_i && !m_sclkp));
            new_err = latch_i && (m_mode == 2);
            w = fmtw(m_held, twos_i);
            if (new_err) begin
                m_mode = 0; m_q.delete(); m_sdout = 0;
            end else if (m_mode == 0 && serial_i && rise) begin
                m_q.delete();
                for (int i = 15; i >= 0; i--) m_q.push_back(w[i]);
                if (!ext_clk_i) begin
                    m_mode = 1; m_tick = 0; m_sdout = m_q.pop_front();
                end else begin
                    m_mode = 2;
                end
            end else if (m_mode == 1) begin
                m_tick++;
                if (m_tick % (2*HALF) == 0) begin
                    if (m_q.size() > 0) m_sdout = m_q.pop_front();
                    if (m_tick == 32*HALF) m_mode = 0;
                end
            end else if (m_mode == 2 && edge_ok) begin
                m_sdout = m_q.pop_front();
                if (m_q.size() == 0) m_mode = 0;
            end
            m_err = new_err;
            if (latch_i) m_held = result_i;
            m_selp = sel;
            m_sclkp = sclk_i;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [15:0] eb, eo, d;
            logic sel;
            sel = !cs_n_i && !rd_n_i;
            if (!serial_i) begin
                eb = fmtw(m_held, twos_i);
                eo = {16{sel}};
            end else begin
                eb = '0; eo = '0;
                eb[8]  = m_sdout;
                eb[9]  = (!ext_clk_i && m_mode == 1) ? (((m_tick / HALF) % 2) == 1) : 1'b0;
                eb[10] = (m_mode == 1) ^ inv_sync_i;
                eb[11] = m_err;
                eo[8] = sel; eo[10] = sel; eo[11] = sel;
                eo[9] = sel && !ext_clk_i;
            end
            checks++;
            d = bus_o ^ eb;
            if (d != 0) begin
                string tg;
                fails++;
                if (!serial_i) tg = "R2";
                else if (d[8]) tg = "R1";
                else if (d[9]) tg = "R4";
                else if (d[10]) tg = "R5";
                else if (d[11]) tg = "R8";
                else tg = "R9";
                $display("FAIL %s bus_o act=%h exp=%h t=%0t", tg, bus_o, eb, $time);
            end
            checks++;
            if (bus_oe_o !== eo) begin
                fails++;
                $display("FAIL R6 bus_oe_o act=%h exp=%h t=%0t", bus_oe_o, eo, $time);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic latch_word(input logic [15:0] w);
        result_i = w; latch_i = 1'b1;
        step();
        latch_i = 1'b0;
    endtask

    task automatic master_read(input logic [15:0] w, input bit mid_latch);
        int rises;
        logic prev;
        logic [15:0] got;
        rises = 0; prev = 1'b0; got = '0;
        cs_n_i = 1'b0; rd_n_i = 1'b0;
        for (int i = 0; i < 32*HALF + 6; i++) begin
            step();
            if (i == 2) chk("R9 master enables", {16'h0, bus_oe_o}, 32'h0F00);
            if (mid_latch && i == 20) begin result_i = 16'h5555; latch_i = 1'b1; end
            if (mid_latch && i == 21) latch_i = 1'b0;
            if (bus_o[9] && !prev) begin got = {got[14:0], bus_o[8]}; rises++; end
            prev = bus_o[9];
        end
        chk("R4 sclk rising count", rises, 16);
        chk("R1 master word", {16'h0, got}, {16'h0, fmtw(w, twos_i)});
        repeat (10) step();
        chk("R10 no restart while selected", {31'h0, bus_o[10]}, {31'h0, inv_sync_i});
        chk("R10 no error from master strobe", {31'h0, bus_o[11]}, 32'h0);
        cs_n_i = 1'b1; rd_n_i = 1'b1;
        step();
    endtask

    task automatic slave_bit(output logic b);
        sclk_i = inv_clk_i ? 1'b0 : 1'b1;   // update edge
        step(); step();
        sclk_i = inv_clk_i ? 1'b1 : 1'b0;   // valid edge
        step();
        b = bus_o[8];
        step();
    endtask

    task automatic slave_read(input logic [15:0] w, input bit gate_test);
        logic [15:0] got;
        logic b;
        got = '0;
        sclk_i = inv_clk_i;
        cs_n_i = 1'b0; rd_n_i = 1'b0;
        step();
        chk("R9 slave enables", {16'h0, bus_oe_o}, 32'h0D00);
        for (int k = 0; k < 16; k++) begin
            if (gate_test && k == 7) begin
                cs_n_i = 1'b1; rd_n_i = 1'b1;
                step();
                for (int t = 0; t < 3; t++) begin
                    sclk_i = ~sclk_i; step();
                    sclk_i = ~sclk_i; step();
                end
                cs_n_i = 1'b0; rd_n_i = 1'b0;
                step();
            end
            slave_bit(b);
            got = {got[14:0], b};
        end
        if (gate_test) chk("R7 gated clock keeps position", {16'h0, got}, {16'h0, fmtw(w, twos_i)});
        else           chk("R3 slave word", {16'h0, got}, {16'h0, fmtw(w, twos_i)});
        cs_n_i = 1'b1; rd_n_i = 1'b1;
        step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog act=running exp=done");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic b;
        repeat (5) step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 bus after reset", {16'h0, bus_o}, 32'h0);
        chk("R11 enables after reset", {16'h0, bus_oe_o}, 32'h0);
        serial_i = 1'b1; step();
        chk("R11 serial idle pins", {16'h0, bus_o}, 32'h0);
        inv_sync_i = 1'b1; step();
        chk("R5 inactive low-active marker", {16'h0, bus_o}, 32'h0400);
        inv_sync_i = 1'b0;

        // R2 / R6 parallel
        serial_i = 1'b0;
        latch_word(16'h1234);
        cs_n_i = 1'b0; rd_n_i = 1'b0; step();
        chk("R2 parallel offset binary", {16'h0, bus_o}, 32'h1234);
        chk("R6 parallel enables", {16'h0, bus_oe_o}, 32'hFFFF);
        twos_i = 1'b1; step();
        chk("R2 parallel twos", {16'h0, bus_o}, 32'h9234);
        latch_word(16'hF00F); step();
        chk("R2 parallel twos msb set", {16'h0, bus_o}, 32'h700F);
        rd_n_i = 1'b1; step();
        chk("R6 read enable high", {16'h0, bus_oe_o}, 32'h0);
        cs_n_i = 1'b1; twos_i = 1'b0; step();

        // Master reads, both marker polarities
        serial_i = 1'b1; ext_clk_i = 1'b0;
        inv_sync_i = 1'b0; twos_i = 1'b0;
        latch_word(16'hA5C3); master_read(16'hA5C3, 1'b0);
        inv_sync_i = 1'b1; twos_i = 1'b1;
        latch_word(16'h0001); master_read(16'h0001, 1'b0);
        inv_sync_i = 1'b0; twos_i = 1'b0;
        latch_word(16'h6E19); master_read(16'h6E19, 1'b1);   // R10 strobe mid-read

        // Slave reads, every edge/polarity pairing
        ext_clk_i = 1'b1;
        for (int ic = 0; ic < 2; ic++) begin
            for (int is = 0; is < 2; is++) begin
                logic [15:0] w;
                w = 16'h8001 ^ 16'(ic * 16'h3A50) ^ 16'(is * 16'h0C3C);
                inv_clk_i = ic[0]; inv_sync_i = is[0]; twos_i = is[0];
                sclk_i = inv_clk_i;
                latch_word(w);
                slave_read(w, (ic == 1 && is == 0));
            end
        end

        // R8 incomplete slave read
        inv_clk_i = 1'b0; inv_sync_i = 1'b0; twos_i = 1'b0; sclk_i = 1'b0;
        latch_word(16'h3C3C);
        cs_n_i = 1'b0; rd_n_i = 1'b0; step();
        for (int k = 0; k < 5; k++) slave_bit(b);
        result_i = 16'h1111; latch_i = 1'b1;
        step();
        latch_i = 1'b0;
        chk("R8 error pulse high", {31'h0, bus_o[11]}, 32'h1);
        step();
        chk("R8 error pulse one cycle", {31'h0, bus_o[11]}, 32'h0);
        for (int k = 0; k < 3; k++) slave_bit(b);
        chk("R8 dropped read stays low", {31'h0, bus_o[8]}, 32'h0);
        cs_n_i = 1'b1; rd_n_i = 1'b1; step();
        slave_read(16'h1111, 1'b0);
        latch_word(16'h2222);
        chk("R8 no error after finished read", {31'h0, bus_o[11]}, 32'h0);
        step();

        finished = 1;
        summary();
        $finish;
    end
endmodule